// File: doc/BRIEF.md
# Command Mailbox with Payload Collector

This block gives software a two-register way to launch multi-word commands. A write to the command register picks an opcode. Each later write to the data register adds one 32-bit word to a collector buffer. Once the collected bytes cover what that opcode needs, the block pulses an execute strobe. The strobe carries the opcode and the whole buffer to an external handler, and in the same cycle the block latches the handler's returned value into a status register.

The byte size each opcode needs is given as a parameter table with one 16-bit entry per opcode, and opcode 0 is the entry at the least significant end. Opcode 0 is reserved as the "unknown" entry. The size check runs on every data write and also right after every command write. As a result, an opcode that needs zero bytes executes as soon as it is written, and any invalid opcode fails at once. The collector is sized by default to the largest payload in the table, and a smaller size can be given instead.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, cmd_status reads 0x0000_0000 (success), no opcode is selected and the word count is zero.
- R2: A command write (bus_sel = 0) whose 32-bit value v satisfies 0 < v < NUM_OPS selects opcode v. Any other value, including 0, selects the unknown entry (opcode 0).
- R3: A command write sets the word count to zero. If the selected opcode does not execute in that same cycle, cmd_status becomes 0xFFFF_FFFE (more data needed) at the next edge.
- R4: A data write (bus_sel = 1) stores the word at the current count position and increments the count. Word i of the payload appears on exec_args bits [32*i+31 : 32*i].
- R5: Execution happens in the cycle of a command or data write when 4 × (word count after that write) ≥ the opcode's table size. The size check runs after the command write too, so zero-size opcodes execute immediately and a size that is not a multiple of 4 rounds up to whole words.
- R6: On execution of a valid opcode, exec_stb is high for that one cycle with exec_op set, and cmd_status takes exec_result at the edge. Afterwards the opcode returns to 0 and the count to zero, so a further data write with no new command fails as unknown.
- R7: Executing the unknown entry sets cmd_status to 0xFFFF_FFFF (failed) without raising exec_stb, and exec_result is ignored.
- R8: A data write when the count already equals the collector depth is discarded. ovf_err is high in that cycle, and neither the count nor cmd_status changes and no execution occurs.
- R9: Writes with bus_sel equal to 2 or 3 change neither the opcode, the count nor cmd_status.
- R10: A command write in the middle of collection drops the partial payload, and the new opcode counts its words from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write enable |
| bus_sel | input | 2 | Register select: 0 command, 1 data, 2 status (read-only), 3 unused |
| bus_wdata | input | 32 | Write data |
| exec_result | input | 32 | Status returned by the external handler in the strobe cycle |
| exec_stb | output | 1 | One-cycle execute strobe |
| exec_op | output | $clog2(NUM_OPS) | Opcode being executed |
| exec_args | output | BUF_WORDS*32 | Collected payload, including the word written in the strobe cycle |
| cmd_status | output | 32 | Status register |
| ovf_err | output | 1 | High in the cycle of a discarded overflowing data write |
| | | | |

## Verification
The bench builds the block with six opcodes: two need zero bytes, one needs 8 bytes, one needs 10 bytes (not a word multiple), one needs 24 bytes and always fails in its handler, and one needs 40 bytes. The collector depth is overridden to 8 words. The 40-byte opcode is then larger than the collector, which makes the overflow path reachable; with the derived default depth, no opcode could ever fill the buffer. The small depth also keeps the payload comparison short while still exercising a rounding-up size, an immediate zero-size execution, and aborting a command part-way through collection.

// File: rtl/cmd_mailbox_pkg.sv
// Shared constants, register select codes and the payload sizing helper
// for the command mailbox. Assumes each table entry is 16 bits wide,
// opcode 0 at the least significant end.
package cmd_mailbox_pkg;
    localparam int DW      = 32;
    localparam int SZ_W    = 16;
    localparam int TBL_OPS = 64;
    localparam int TBL_W   = TBL_OPS * SZ_W;

    localparam logic [DW-1:0] ST_OK    = 32'h0000_0000;
    localparam logic [DW-1:0] ST_FAIL  = 32'hFFFF_FFFF;
    localparam logic [DW-1:0] ST_SHORT = 32'hFFFF_FFFE;

    typedef enum logic [1:0] {
        SEL_CMD    = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Largest payload in the table, rounded up to whole words, at least 1.
    function automatic int largest_payload_words(input logic [TBL_W-1:0] tbl, input int n);
        int best;
        best = 1;
        for (int i = 0; i < TBL_OPS; i++) begin
            if (i < n) begin
                int w;
                w = (int'(tbl[i*SZ_W +: SZ_W]) + 3) / 4;
                if (w > best) best = w;
            end
        end
        return best;
    endfunction
endpackage

// File: rtl/cmd_len_check.sv
// Compares the bytes collected so far against the size the opcode needs.
// Assumes op < NUM_OPS; any other value reads as size zero.
module cmd_len_check
    import cmd_mailbox_pkg::*;
#(
    parameter int NUM_OPS = 2,
    parameter logic [NUM_OPS*SZ_W-1:0] OP_BYTES = '0,
    parameter int OP_W  = 1,
    parameter int CNT_W = 1
)(
    input  logic [OP_W-1:0]  op,
    input  logic [CNT_W-1:0] words,
    output logic             enough
);
    logic [SZ_W-1:0] need_tbl [NUM_OPS];
    logic [SZ_W-1:0] need;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_tbl
        assign need_tbl[g] = OP_BYTES[g*SZ_W +: SZ_W];
    end

    // Look up the required byte count and compare it with words*4.
    always_comb begin
        need = '0;
        for (int i = 0; i < NUM_OPS; i++) begin
            if (op == OP_W'(i)) need = need_tbl[i];
        end
        enough = ((32'(words) << 2) >= 32'(need));
    end
endmodule

// File: rtl/cmd_collector.sv
// Payload word store. Writes one word at wr_idx when wr_en is set. The
// outgoing payload already shows the word being written, so an execution
// in the same cycle sees the complete payload.
module cmd_collector
    import cmd_mailbox_pkg::*;
#(
    parameter int WORDS = 1,
    parameter int CNT_W = 1
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CNT_W-1:0]    wr_idx,
    input  logic [DW-1:0]       wr_word,
    output logic [WORDS*DW-1:0] payload
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DW-1:0] word_q;
        logic          hit;

        assign hit = wr_en && (wr_idx == CNT_W'(g));

        // Capture the incoming word into its slot.
        always_ff @(posedge clk) begin
            if (!rst_n)   word_q <= '0;
            else if (hit) word_q <= wr_word;
        end

        assign payload[g*DW +: DW] = hit ? wr_word : word_q;
    end
endmodule

// File: rtl/cmd_mailbox.sv
// Command mailbox top. Decodes writes to the command and data registers,
// tracks the selected opcode and the word count, fires the execute strobe
// once the payload is long enough, and latches the result into status.
// Assumes the handler returns exec_result combinationally in the strobe cycle.
module cmd_mailbox
    import cmd_mailbox_pkg::*;
#(
    parameter int NUM_OPS = 10,
    parameter logic [NUM_OPS*SZ_W-1:0] OP_BYTES = {
        16'd8, 16'd0, 16'd16, 16'd0, 16'd12,
        16'd160, 16'd0, 16'd0, 16'd24, 16'd0 },
    parameter int COLLECT_WORDS = 0,
    localparam int BUF_WORDS = (COLLECT_WORDS > 0) ? COLLECT_WORDS
                             : largest_payload_words(TBL_W'(OP_BYTES), NUM_OPS),
    localparam int OP_W  = $clog2(NUM_OPS),
    localparam int CNT_W = $clog2(BUF_WORDS + 1)
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [1:0]              bus_sel,
    input  logic [DW-1:0]           bus_wdata,
    input  logic [DW-1:0]           exec_result,
    output logic                    exec_stb,
    output logic [OP_W-1:0]         exec_op,
    output logic [BUF_WORDS*DW-1:0] exec_args,
    output logic [DW-1:0]           cmd_status,
    output logic                    ovf_err
);
    logic [OP_W-1:0]  op_q, cand_op;
    logic [CNT_W-1:0] cnt_q, cand_cnt;
    logic [DW-1:0]    status_q;
    logic cmd_wr, dat_wr, cmd_ok, full, take, probe, enough, fire;

    // Decode the write and form the candidate opcode and count.
    always_comb begin
        cmd_wr   = bus_wr && (bus_sel == SEL_CMD);
        dat_wr   = bus_wr && (bus_sel == SEL_DATA);
        cmd_ok   = (bus_wdata != '0) && (bus_wdata < DW'(NUM_OPS));
        full     = (cnt_q == CNT_W'(BUF_WORDS));
        take     = dat_wr && !full;
        cand_op  = cmd_wr ? (cmd_ok ? bus_wdata[OP_W-1:0] : '0) : op_q;
        cand_cnt = cmd_wr ? '0 : (take ? cnt_q + 1'b1 : cnt_q);
        probe    = cmd_wr || take;
        fire     = probe && enough;
    end

    cmd_len_check #(
        .NUM_OPS (NUM_OPS),
        .OP_BYTES(OP_BYTES),
        .OP_W    (OP_W),
        .CNT_W   (CNT_W)
    ) u_len (
        .op    (cand_op),
        .words (cand_cnt),
        .enough(enough)
    );

    cmd_collector #(
        .WORDS(BUF_WORDS),
        .CNT_W(CNT_W)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (take),
        .wr_idx (cnt_q),
        .wr_word(bus_wdata),
        .payload(exec_args)
    );

    // Advance opcode, count and status; an execution returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            cnt_q    <= '0;
            status_q <= ST_OK;
        end else begin
            if (fire) begin
                op_q     <= '0;
                cnt_q    <= '0;
                status_q <= (cand_op == '0) ? ST_FAIL : exec_result;
            end else begin
                op_q  <= cand_op;
                cnt_q <= cand_cnt;
                if (cmd_wr) status_q <= ST_SHORT;
            end
        end
    end

    assign exec_stb   = fire && (cand_op != '0);
    assign exec_op    = cand_op;
    assign cmd_status = status_q;
    assign ovf_err    = dat_wr && full;

    // R3
    cmd_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !fire) |=> (cmd_status == ST_SHORT) && (cnt_q == '0));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !fire) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6
    idle_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (op_q == '0) && (cnt_q == '0));

    // R7
    unknown_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_sel == SEL_CMD) &&
         !((bus_wdata != '0) && (bus_wdata < DW'(NUM_OPS))))
        |=> (cmd_status == ST_FAIL));

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> (cnt_q == $past(cnt_q)) && (cmd_status == $past(cmd_status)));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BUF_WORDS));
endmodule

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;
    localparam int NOPS  = 6;
    localparam int DEPTH = 8;
    localparam logic [31:0] S_OK    = 32'h0000_0000;
    localparam logic [31:0] S_FAIL  = 32'hFFFF_FFFF;
    localparam logic [31:0] S_SHORT = 32'hFFFF_FFFE;

    logic clk = 0, rst_n = 0, bus_wr = 0;
    logic [1:0] bus_sel = 2'd3;
    logic [31:0] bus_wdata = '0;
    logic [31:0] exec_result;
    logic exec_stb, ovf_err;
    logic [2:0] exec_op;
    logic [DEPTH*32-1:0] exec_args;
    logic [31:0] cmd_status;

    int sizes [NOPS] = '{0, 24, 0, 8, 10, 40};
    int tests = 0, fails = 0;
    bit started = 0;

    int m_op = 0, m_cnt = 0;
    logic [31:0] m_status = S_OK;
    logic [31:0] m_buf [DEPTH];

    always #5 clk = ~clk;

    function automatic logic [31:0] handler(input int op);
        return (op == 1) ? S_FAIL : 32'h100 + 32'(op);
    endfunction

    assign exec_result = handler(int'(exec_op));

    cmd_mailbox #(
        .NUM_OPS(NOPS),
        .OP_BYTES({16'd40, 16'd10, 16'd8, 16'd0, 16'd24, 16'd0}),
        .COLLECT_WORDS(DEPTH)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .exec_result(exec_result), .exec_stb(exec_stb),
        .exec_op(exec_op), .exec_args(exec_args), .cmd_status(cmd_status),
        .ovf_err(ovf_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of the status register against the model.
    always @(negedge clk) begin
        if (started) begin
            chk(cmd_status === m_status, "R6 status model", cmd_status, m_status);
            if (!bus_wr) chk(!exec_stb && !ovf_err, "R9 quiet outputs",
                             {30'b0, exec_stb, ovf_err}, 32'h0);
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d, input string tag);
        int n_op = m_op, n_cnt = m_cnt;
        logic [31:0] n_st = m_status;
        bit probe = 0, ovf = 0, fire = 0, stb = 0;
        logic [31:0] nb [DEPTH];
        nb = m_buf;
        if (sel == 2'd0) begin
            n_op = (d != 0 && d < NOPS) ? int'(d) : 0;
            n_cnt = 0; n_st = S_SHORT; probe = 1;
        end else if (sel == 2'd1) begin
            if (n_cnt == DEPTH) ovf = 1;
            else begin nb[n_cnt] = d; n_cnt++; probe = 1; end
        end
        if (probe && n_cnt * 4 >= sizes[n_op]) begin
            fire = 1; stb = (n_op != 0);
            n_st = (n_op == 0) ? S_FAIL : handler(n_op);
        end
        @(negedge clk);
        bus_wr = 1; bus_sel = sel; bus_wdata = d;
        #1;
        chk(exec_stb === stb, {tag, " strobe"}, 32'(exec_stb), 32'(stb));
        if (stb) begin
            chk(exec_op === 3'(n_op), {tag, " opcode"}, 32'(exec_op), 32'(n_op));
            for (int i = 0; i < n_cnt; i++)
                chk(exec_args[i*32 +: 32] === nb[i], {tag, " payload"}, exec_args[i*32 +: 32], nb[i]);
        end
        chk(ovf_err === ovf, {tag, " overflow flag"}, 32'(ovf_err), 32'(ovf));
        @(posedge clk); #1;
        bus_wr = 0; bus_sel = 2'd3;
        m_buf = nb; m_status = n_st;
        if (fire) begin m_op = 0; m_cnt = 0; end
        else begin m_op = n_op; m_cnt = n_cnt; end
    endtask

    initial begin
        #(200000 * 10);
        fails++; tests++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_buf[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(cmd_status === S_OK, "R1 reset status", cmd_status, S_OK);
        @(negedge clk); rst_n = 1; started = 1;
        // R1: after reset, a size-8 opcode needs exactly two words
        wr(2'd0, 32'd3, "R2");
        wr(2'd1, 32'hA5A5_0001, "R4");
        wr(2'd1, 32'h5A5A_0002, "R5");
        // R5: 10 bytes round up to three words
        wr(2'd0, 32'd4, "R3");
        wr(2'd1, 32'h1111_1111, "R4");
        wr(2'd1, 32'h2222_2222, "R4");
        wr(2'd1, 32'h3333_3333, "R5");
        // R5: zero-size opcode executes on the command write
        wr(2'd0, 32'd2, "R5");
        // R7: invalid values fall back to the unknown entry
        wr(2'd0, 32'd0, "R7");
        wr(2'd0, 32'd6, "R2");
        wr(2'd0, 32'h8000_0001, "R7");
        // R6: data with no command executes as unknown
        wr(2'd1, 32'hDEAD_BEEF, "R6");
        // Handler that fails after six words
        wr(2'd0, 32'd1, "R3");
        for (int i = 0; i < 6; i++) wr(2'd1, 32'h600 + 32'(i), "R6");
        // R9: other selects are ignored mid-collection
        wr(2'd0, 32'd3, "R3");
        wr(2'd1, 32'h0000_00AA, "R4");
        wr(2'd2, 32'd5, "R9");
        wr(2'd3, 32'd0, "R9");
        wr(2'd1, 32'h0000_00BB, "R9");
        // R10: abort partial payload with a new command
        wr(2'd0, 32'd4, "R10");
        wr(2'd1, 32'hC000_0001, "R10");
        wr(2'd0, 32'd4, "R10");
        wr(2'd1, 32'hC000_0002, "R10");
        wr(2'd1, 32'hC000_0003, "R10");
        wr(2'd1, 32'hC000_0004, "R10");
        // R8: opcode larger than the collector overflows
        wr(2'd0, 32'd5, "R8");
        for (int i = 0; i < DEPTH; i++) wr(2'd1, 32'h800 + 32'(i), "R8");
        wr(2'd1, 32'h0BAD_0001, "R8");
        wr(2'd1, 32'h0BAD_0002, "R8");
        chk(cmd_status === S_SHORT, "R8 status held", cmd_status, S_SHORT);
        wr(2'd0, 32'd3, "R10");
        wr(2'd1, 32'h7777_0000, "R4");
        wr(2'd1, 32'h7777_0001, "R5");
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule